// File: doc/BRIEF.md
# Change-Detect Interrupt Sensor Port

This block connects an 8-bit sensor to a small processor through a simple handshake-style port bus. The sensor value passes through a short synchroniser chain. The last stage of that chain is the current sample, and a further register keeps the sample taken one clock earlier. When the two differ, the block sets a sticky interrupt request. That request stays asserted until the processor pulses a dedicated acknowledge input. A new change that arrives in the same cycle as an acknowledge wins over the acknowledge, so no event is lost.

The processor reads the current sample on the data output. A bus cycle is acknowledged in the same cycle that both cycle and strobe are high. An active-low asynchronous reset clears every sample register and the request. After reset, no interrupt is raised until the pipeline holds two real samples, so the first value seen after reset never counts as a change.

Top module: `sensor_chg_port`

## Requirements
- R1: While rst_ni is low, int_req_o is 0 and dat_o is 0, and this holds as soon as reset is asserted, without waiting for a clock edge.
- R2: dat_o shows the sensor_i value sampled SYNC_STAGES rising edges earlier (2 with default parameters).
- R3: ack_o is 1 in exactly those cycles where cyc_i and stb_i are both 1, in the same cycle, with no added latency.
- R4: A change of sensor_i raises int_req_o at the (SYNC_STAGES+1)-th rising edge after the change, and not earlier.
- R5: Once set, int_req_o stays 1 for as long as int_ack_i is 0, whatever the sensor does.
- R6: int_ack_i high at an edge, with no change detected in that cycle, clears int_req_o at that edge.
- R7: When a change is detected in the same cycle as int_ack_i is high, int_req_o is 1 after that edge.
- R8: The first sample after reset does not raise int_req_o, even when the sensor holds a non-zero value throughout reset.
- R9: A steady sensor value never raises int_req_o, and pulsing int_ack_i while no request is pending leaves int_req_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sensor_i | input | DATA_W | Raw sensor value |
| cyc_i | input | 1 | Bus cycle qualifier |
| stb_i | input | 1 | Bus strobe |
| ack_o | output | 1 | Bus acknowledge |
| dat_o | output | DATA_W | Current synchronised sample |
| int_ack_i | input | 1 | Processor interrupt acknowledge |
| int_req_o | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach is the collision between a freshly detected change and the processor acknowledge. The change exists internally for only one cycle, and it starts a fixed number of edges after the sensor moves. To hit it, the stimulus first raises a request with one change. It then applies a second sensor value and counts exactly SYNC_STAGES edges before holding int_ack_i high for a single edge. After that edge the request must still be set, and a later, lone acknowledge must clear it. The start-up suppression is reached by holding a non-zero sensor value through reset.

// File: rtl/sensor_port_pkg.sv
package sensor_port_pkg;
  localparam int unsigned DEF_DATA_W      = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/sensor_sampler.sv
module sensor_sampler #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sensor_i,
  output logic [DATA_W-1:0] cur_o,
  output logic              change_o
);
  localparam int unsigned CW = $clog2(STAGES + 2);
  localparam logic [CW-1:0] ARM = CW'(STAGES + 1);

  logic [DATA_W-1:0] stage_q [STAGES];
  logic [DATA_W-1:0] prev_q;
  logic [CW-1:0]     fill_q;
  logic              armed;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[g] <= '0;
      else if (g == 0) stage_q[g] <= sensor_i;
      else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
    if (g > 0) begin : g_chk
      AST_STAGE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stage_q[g] == $past(stage_q[g-1])); // R2
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      prev_q <= stage_q[STAGES-1];
      if (fill_q != ARM) fill_q <= fill_q + 1'b1;
    end
  end

  // compare only once prev_q holds a real sample
  assign armed    = (fill_q == ARM);
  assign cur_o    = stage_q[STAGES-1];
  assign change_o = armed && (stage_q[STAGES-1] != prev_q);

  AST_PRIME_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> !change_o); // R8
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic change_i,
  input  logic int_ack_i,
  output logic int_req_o
);
  logic req_q;

  // set has priority over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        req_q <= 1'b0;
    else if (change_i)  req_q <= 1'b1;
    else if (int_ack_i) req_q <= 1'b0;
  end

  assign int_req_o = req_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !int_ack_i |=> req_q); // R5
  AST_REQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_i && !change_i |=> !req_q); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_i && int_ack_i |=> req_q); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && !change_i |=> !req_q); // R9
endmodule

// File: rtl/port_read.sv
module port_read #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] dat_o
);
  assign ack_o = cyc_i & stb_i;
  assign dat_o = sample_i;

  always_comb begin
    if (!cyc_i) AST_ACK_NEEDS_CYC: assert (!ack_o); // R3
  end
endmodule

// File: rtl/sensor_chg_port.sv
module sensor_chg_port
  import sensor_port_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sensor_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] dat_o,
  input  logic              int_ack_i,
  output logic              int_req_o
);
  logic [DATA_W-1:0] cur;
  logic              change;

  sensor_sampler #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sensor_i (sensor_i),
    .cur_o    (cur),
    .change_o (change)
  );

  irq_latch u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .change_i  (change),
    .int_ack_i (int_ack_i),
    .int_req_o (int_req_o)
  );

  port_read #(.DATA_W(DATA_W)) u_read (
    .cyc_i    (cyc_i),
    .stb_i    (stb_i),
    .sample_i (cur),
    .ack_o    (ack_o),
    .dat_o    (dat_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !int_req_o && dat_o == '0); // R1
endmodule

// File: tb/tb_sensor_chg_port.sv
`timescale 1ns/1ps
module tb_sensor_chg_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sensor = '0;
  logic       cyc = 1'b0, stb = 1'b0, int_ack = 1'b0;
  logic       ack;
  logic [7:0] dat;
  logic       int_req;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  sensor_chg_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .sensor_i(sensor), .cyc_i(cyc), .stb_i(stb),
    .ack_o(ack), .dat_o(dat), .int_ack_i(int_ack), .int_req_o(int_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; sensor = 8'h00; step(2);
    chk(int_req == 1'b0, "R1 req", int_req, 0);
    chk(dat == 8'h00, "R1 dat", dat, 0);
  endtask

  task automatic t_prime;
    sensor = 8'hA5; rst_ni = 1'b0; step(2);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(int_req == 1'b0, "R8 no first-sample irq", int_req, 0);
    end
    chk(dat == 8'hA5, "R2 dat after prime", dat, 8'hA5);
  endtask

  task automatic t_read;
    for (int c = 0; c < 4; c++) begin
      cyc = c[0]; stb = c[1]; #1;
      chk(ack == (c == 3), "R3 ack", ack, int'(c == 3));
      step();
    end
    cyc = 1'b0; stb = 1'b0;
  endtask

  task automatic t_change;
    sensor = 8'h3C; step();
    chk(int_req == 1'b0, "R4 not early 1", int_req, 0);
    chk(dat == 8'hA5, "R2 dat unchanged after 1 edge", dat, 8'hA5);
    step();
    chk(int_req == 1'b0, "R4 not early 2", int_req, 0);
    chk(dat == 8'h3C, "R2 dat after 2 edges", dat, 8'h3C);
    step();
    chk(int_req == 1'b1, "R4 raised", int_req, 1);
    sensor = 8'h3D;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(int_req == 1'b1, "R5 sticky", int_req, 1);
    end
  endtask

  task automatic t_ack;
    step(3);
    int_ack = 1'b1; step(); int_ack = 1'b0;
    chk(int_req == 1'b0, "R6 cleared", int_req, 0);
    step(2);
    chk(int_req == 1'b0, "R6 stays clear", int_req, 0);
  endtask

  task automatic t_collide;
    sensor = 8'h11; step(3);
    chk(int_req == 1'b1, "R7 setup raised", int_req, 1);
    sensor = 8'h22; step(2);
    int_ack = 1'b1; step(); int_ack = 1'b0;
    chk(int_req == 1'b1, "R7 change beats ack", int_req, 1);
    step(2);
    int_ack = 1'b1; step(); int_ack = 1'b0;
    chk(int_req == 1'b0, "R7 later ack clears", int_req, 0);
  endtask

  task automatic t_quiet;
    int_ack = 1'b1; step(); int_ack = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(int_req == 1'b0, "R9 steady no irq", int_req, 0);
    end
    chk(dat == 8'h22, "R2 steady dat", dat, 8'h22);
  endtask

  task automatic t_async_reset;
    sensor = 8'h5A; step(3);
    chk(int_req == 1'b1, "R4 raised before reset", int_req, 1);
    #0.5 rst_ni = 1'b0; #0.5;
    chk(int_req == 1'b0, "R1 async req", int_req, 0);
    chk(dat == 8'h00, "R1 async dat", dat, 0);
    step(); rst_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_prime();
    t_read();
    t_change();
    t_ack();
    t_collide();
    t_quiet();
    t_async_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule